// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block is the timekeeping core of a battery-backed clock. It holds the time as eight packed-BCD bytes: hundredths, seconds, minutes, hours, weekday, date, month and year. On every clock cycle where the 100 Hz enable `tick` is high and the oscillator-stop bit is clear, it advances that state by one hundredth of a second. Carries ripple through the whole calendar within that one cycle. Month lengths and February of years divisible by four are handled without help. Hours run in either a 12-hour (AM/PM) or a 24-hour form, chosen by a bit stored inside the hours byte.

A neighbouring serial access unit reaches the core through a parallel register-file port. A single-cycle bulk load replaces all eight bytes at once. A snapshot request copies all eight bytes into an output register that holds still while the unit shifts it out. The weekday byte also carries two control bits. One stops the count. The other decides whether the active-low external reset line may abort a serial transfer in progress; such an abort never alters the time.

Top module: `bcd_calendar_core`

## Requirements
- R1: After synchronous reset a snapshot reads year 00, month 01, date 01, weekday byte 0x31 (stop bit 5 and mask bit 4 set, weekday 1), and hours, minutes, seconds and hundredths all 00 (24-hour form).
- R2: While bit 5 of the weekday byte is 1, `tick` changes no register; when it is 0 each tick cycle advances the hundredths by one.
- R3: When `load_en` is high, all eight bytes take the value on `load_data` in that cycle, with byte i at bits 8i+7..8i (0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month, 7 year); a load in the same cycle as a tick wins, and the tick is lost.
- R4: Bits with no meaning always read 0 whatever is loaded; the kept-bit masks are seconds 0x7F, minutes 0x7F, hours 0xBF, weekday 0x37, date 0x3F, month 0x1F, and hundredths and year keep all 8 bits.
- R5: Hundredths wrap 99 to 00 and carry into seconds; seconds and minutes wrap 59 to 00 and carry into the next field; units digits roll 9 to 0 with a tens increment.
- R6: With hours bit 7 at 0 (24-hour), hours run 00 to 23 with bit 5 as the tens-of-twenty bit, and 23 wraps to 00 with a carry into weekday and date.
- R7: With hours bit 7 at 1 (12-hour), bits 4..0 run 01 to 12 and bit 5 is PM; the step 11 to 12 inverts PM, the step 12 to 01 keeps it, and only 11 PM to 12 AM carries into weekday and date.
- R8: The weekday field (bits 2..0) runs 1 to 7 and wraps to 1, leaving bits 5 and 4 of that byte untouched.
- R9: The date wraps to 01 after 30 in months 04, 06, 09 and 11, after 31 in the other months except February, and in February after 29 when the year is divisible by four (00 included) or after 28 otherwise, carrying into the month.
- R10: Month 12 wraps to 01 and increments the year; year 99 wraps to 00.
- R11: One cycle after `ext_rst_n` is sampled low while weekday bit 4 is 0, `xfer_abort` is high; it stays low whenever bit 4 is 1, and no time byte changes because of it.
- R12: `snap_data` takes the eight bytes as they stood in the cycle `snap_req` was sampled high, and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 100 Hz count enable, one cycle per hundredth |
| load_en | input | 1 | Bulk load strobe for all eight bytes |
| load_data | input | 64 | Bulk load image, byte i in bits 8i+7..8i |
| snap_req | input | 1 | Snapshot capture strobe |
| snap_data | output | 64 | Registered snapshot image, same packing |
| ext_rst_n | input | 1 | Active-low external reset line |
| xfer_abort | output | 1 | Registered request to abort a serial transfer |

## Verification
Every result here is due exactly one rising edge after its cause. A load is in the state at the next edge. Each enabled tick advances the whole calendar at its own edge. `snap_data` shows the state one edge after `snap_req`. `xfer_abort` follows a low `ext_rst_n` by one edge. The bench changes inputs just after a falling edge and reads outputs at the next falling edge, so every check lands half a cycle after the edge that made the value. A snapshot is taken only after the tick enable has dropped, so its expected image counts precisely the ticks driven.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int unsigned REG_W = 8;
  localparam int unsigned NREGS = 8;
  localparam int unsigned BUS_W = REG_W * NREGS;

  localparam int unsigned IX_HUND = 0;
  localparam int unsigned IX_SEC  = 1;
  localparam int unsigned IX_MIN  = 2;
  localparam int unsigned IX_HOUR = 3;
  localparam int unsigned IX_WDAY = 4;
  localparam int unsigned IX_DATE = 5;
  localparam int unsigned IX_MON  = 6;
  localparam int unsigned IX_YEAR = 7;

  // control bits kept in the weekday byte
  localparam int unsigned OSC_STOP_BIT = 5;
  localparam int unsigned RST_MASK_BIT = 4;
  localparam int unsigned WDAY_W       = 3;

  typedef logic [REG_W-1:0] creg_t;

  // bits a byte may hold; the rest always read 0
  function automatic creg_t field_mask(input int unsigned ix);
    case (ix)
      IX_SEC, IX_MIN: return 8'h7F;
      IX_HOUR:        return 8'hBF;
      IX_WDAY:        return 8'h37;
      IX_DATE:        return 8'h3F;
      IX_MON:         return 8'h1F;
      default:        return 8'hFF;
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] bus_mask();
    logic [BUS_W-1:0] m;
    for (int unsigned i = 0; i < NREGS; i++) m[i*REG_W +: REG_W] = field_mask(i);
    return m;
  endfunction

  function automatic creg_t reset_value(input int unsigned ix);
    case (ix)
      IX_WDAY:        return 8'h31;
      IX_DATE, IX_MON: return 8'h01;
      default:        return 8'h00;
    endcase
  endfunction

  // range of the plain wrapping counters
  function automatic creg_t count_lo(input int unsigned ix);
    case (ix)
      IX_WDAY, IX_MON: return 8'h01;
      default:         return 8'h00;
    endcase
  endfunction

  function automatic creg_t count_hi(input int unsigned ix);
    case (ix)
      IX_SEC, IX_MIN: return 8'h59;
      IX_WDAY:        return 8'h07;
      IX_MON:         return 8'h12;
      default:        return 8'h99;
    endcase
  endfunction

  // which field's carry steps field ix (hundredths is stepped by the tick)
  function automatic int unsigned carry_src(input int unsigned ix);
    case (ix)
      IX_SEC:           return IX_HUND;
      IX_MIN:           return IX_SEC;
      IX_HOUR:          return IX_MIN;
      IX_WDAY, IX_DATE: return IX_HOUR;
      IX_MON:           return IX_DATE;
      IX_YEAR:          return IX_MON;
      default:          return IX_HUND;
    endcase
  endfunction

  function automatic creg_t bcd_inc(input creg_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    else                return v + 8'd1;
  endfunction

  function automatic logic leap_bcd(input creg_t y);
    logic [7:0] bin;
    bin = ({4'b0000, y[7:4]} * 8'd10) + {4'b0000, y[3:0]};
    return (bin[1:0] == 2'b00);
  endfunction

  function automatic creg_t month_last(input creg_t m, input creg_t y);
    case (m)
      8'h02:                      return leap_bcd(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_wrap_counter.sv
module cal_wrap_counter
  import cal_pkg::*;
#(
  parameter creg_t LO = 8'h00,
  parameter creg_t HI = 8'h99
) (
  input  creg_t cur,
  input  logic  inc,
  output creg_t nxt,
  output logic  carry
);

  logic wrap;

  // >= also pulls an out-of-range loaded value back into range
  assign wrap  = (cur >= HI);
  assign carry = inc & wrap;
  assign nxt   = !inc ? cur : (wrap ? LO : bcd_inc(cur));

endmodule

// File: rtl/cal_hour_step.sv
module cal_hour_step
  import cal_pkg::*;
(
  input  logic       mode12,
  input  logic [5:0] hr,
  input  logic       inc,
  output creg_t      nxt,
  output logic       carry
);

  always_comb begin
    nxt   = {mode12, 1'b0, hr};
    carry = 1'b0;
    if (inc) begin
      if (mode12) begin
        // hr[5] is PM, hr[4:0] is 01..12
        if (hr[4:0] == 5'h11) begin
          nxt   = {2'b10, ~hr[5], 5'h12};
          carry = hr[5];
        end else if (hr[4:0] >= 5'h12) begin
          nxt = {2'b10, hr[5], 5'h01};
        end else if (hr[3:0] >= 4'd9) begin
          nxt = {2'b10, hr[5], 1'b1, 4'h0};
        end else begin
          nxt = {2'b10, hr[5], hr[4], hr[3:0] + 4'd1};
        end
      end else begin
        // hr[5:4] is the tens digit 0..2
        if (hr >= 6'h23) begin
          nxt   = 8'h00;
          carry = 1'b1;
        end else if (hr[3:0] >= 4'd9) begin
          nxt = {2'b00, hr[5:4] + 2'd1, 4'h0};
        end else begin
          nxt = {2'b00, hr[5:4], hr[3:0] + 4'd1};
        end
      end
    end
  end

endmodule

// File: rtl/cal_date_step.sv
module cal_date_step
  import cal_pkg::*;
(
  input  creg_t date,
  input  creg_t month,
  input  creg_t year,
  input  logic  inc,
  output creg_t nxt,
  output logic  carry
);

  creg_t last;
  logic  wrap;

  assign last  = month_last(month, year);
  assign wrap  = (date >= last);
  assign carry = inc & wrap;
  assign nxt   = !inc ? date : (wrap ? 8'h01 : bcd_inc(date));

endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
  import cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load_en,
  input  logic [BUS_W-1:0] load_data,
  input  logic             snap_req,
  output logic [BUS_W-1:0] snap_data,
  input  logic             ext_rst_n,
  output logic             xfer_abort
);

  logic [NREGS-1:0][REG_W-1:0] regs_q;
  logic [BUS_W-1:0]            snap_q;
  logic                        abort_q;
  logic                        run;

  creg_t fld_nxt   [NREGS];
  logic  fld_inc   [NREGS];
  logic  fld_carry [NREGS];

  assign run = tick & ~regs_q[IX_WDAY][OSC_STOP_BIT];

  // carry chain: every field is stepped by the carry of its lower neighbour
  always_comb begin
    for (int unsigned i = 0; i < NREGS; i++) begin
      fld_inc[i] = (i == IX_HUND) ? run : fld_carry[carry_src(i)];
    end
  end

  for (genvar gi = 0; gi < NREGS; gi++) begin : g_field
    if (gi == IX_HOUR) begin : g_hour
      cal_hour_step u_hour (
        .mode12 (regs_q[gi][7]),
        .hr     (regs_q[gi][5:0]),
        .inc    (fld_inc[gi]),
        .nxt    (fld_nxt[gi]),
        .carry  (fld_carry[gi])
      );
    end else if (gi == IX_DATE) begin : g_date
      cal_date_step u_date (
        .date   (regs_q[gi]),
        .month  (regs_q[IX_MON]),
        .year   (regs_q[IX_YEAR]),
        .inc    (fld_inc[gi]),
        .nxt    (fld_nxt[gi]),
        .carry  (fld_carry[gi])
      );
    end else if (gi == IX_WDAY) begin : g_wday
      creg_t wd_nxt;
      cal_wrap_counter #(
        .LO (count_lo(gi)),
        .HI (count_hi(gi))
      ) u_wday (
        .cur    ({{(REG_W-WDAY_W){1'b0}}, regs_q[gi][WDAY_W-1:0]}),
        .inc    (fld_inc[gi]),
        .nxt    (wd_nxt),
        .carry  (fld_carry[gi])
      );
      // control bits ride along untouched
      assign fld_nxt[gi] = {regs_q[gi][REG_W-1:WDAY_W], wd_nxt[WDAY_W-1:0]};
    end else begin : g_plain
      cal_wrap_counter #(
        .LO (count_lo(gi)),
        .HI (count_hi(gi))
      ) u_cnt (
        .cur    (regs_q[gi]),
        .inc    (fld_inc[gi]),
        .nxt    (fld_nxt[gi]),
        .carry  (fld_carry[gi])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int unsigned i = 0; i < NREGS; i++) regs_q[i] <= reset_value(i);
    end else if (load_en) begin
      for (int unsigned i = 0; i < NREGS; i++)
        regs_q[i] <= load_data[i*REG_W +: REG_W] & field_mask(i);
    end else begin
      for (int unsigned i = 0; i < NREGS; i++) regs_q[i] <= fld_nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q  <= '0;
      abort_q <= 1'b0;
    end else begin
      if (snap_req) snap_q <= regs_q;
      abort_q <= ~ext_rst_n & ~regs_q[IX_WDAY][RST_MASK_BIT];
    end
  end

  assign snap_data  = snap_q;
  assign xfer_abort = abort_q;

endmodule

// File: rtl/cal_core_checker.sv
module cal_core_checker
  import cal_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             load_en,
  input logic [BUS_W-1:0] load_data,
  input logic [BUS_W-1:0] regs,
  input logic             snap_req,
  input logic [BUS_W-1:0] snap_data,
  input logic             ext_rst_n,
  input logic             xfer_abort
);

  localparam logic [BUS_W-1:0] KEEP = bus_mask();
  localparam int unsigned STOP_POS = IX_WDAY*REG_W + OSC_STOP_BIT;
  localparam int unsigned MASK_POS = IX_WDAY*REG_W + RST_MASK_BIT;

  p_stopped_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!load_en && regs[STOP_POS]) |=> $stable(regs));

  p_bulk_load_r3: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (regs == ($past(load_data) & KEEP)));

  p_zero_bits_r4: assert property (@(posedge clk) disable iff (rst)
    ((regs & ~KEEP) == '0));

  p_abort_raise_r11: assert property (@(posedge clk) disable iff (rst)
    (!ext_rst_n && !regs[MASK_POS]) |=> xfer_abort);

  p_abort_masked_r11: assert property (@(posedge clk) disable iff (rst)
    regs[MASK_POS] |=> !xfer_abort);

  p_snap_take_r12: assert property (@(posedge clk) disable iff (rst)
    snap_req |=> (snap_data == $past(regs)));

  p_snap_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !snap_req |=> $stable(snap_data));

endmodule

bind bcd_calendar_core cal_core_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .load_en    (load_en),
  .load_data  (load_data),
  .regs       (regs_q),
  .snap_req   (snap_req),
  .snap_data  (snap_data),
  .ext_rst_n  (ext_rst_n),
  .xfer_abort (xfer_abort)
);

// File: tb/bcd_calendar_core_test.sv
module bcd_calendar_core_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        load_en = 1'b0;
  logic [63:0] load_data = '0;
  logic        snap_req = 1'b0;
  logic [63:0] snap_data;
  logic        ext_rst_n = 1'b1;
  logic        xfer_abort;

  int n_checks = 0;
  int n_fail = 0;

  bcd_calendar_core uut (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .load_en    (load_en),
    .load_data  (load_data),
    .snap_req   (snap_req),
    .snap_data  (snap_data),
    .ext_rst_n  (ext_rst_n),
    .xfer_abort (xfer_abort)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] pk(input logic [7:0] yr, mo, da, wd, hr, mi, se, hu);
    return {yr, mo, da, wd, hr, mi, se, hu};
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_load(input logic [63:0] v);
    load_en = 1'b1; load_data = v;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_snap(output logic [63:0] v);
    snap_req = 1'b1;
    @(negedge clk);
    snap_req = 1'b0;
    v = snap_data;
  endtask

  // load, tick n times, snapshot, compare
  task automatic roll(input string req, input logic [63:0] start, input int n, input logic [63:0] exp);
    logic [63:0] got;
    do_load(start);
    do_ticks(n);
    do_snap(got);
    check(req, got, exp);
  endtask

  task automatic t_reset;
    logic [63:0] got;
    do_snap(got);
    check("R1 reset image", got, 64'h0001_0131_0000_0000);
  endtask

  task automatic t_stopped;
    logic [63:0] got;
    do_ticks(5);
    do_snap(got);
    check("R2 stop bit blocks ticks", got, 64'h0001_0131_0000_0000);
  endtask

  task automatic t_load_mask;
    logic [63:0] got;
    logic [63:0] a;
    do_load('1);
    do_snap(got);
    check("R4 unused bits read zero", got, 64'hFF1F_3F37_BF7F_7FFF);
    a = pk(8'h24, 8'h03, 8'h15, 8'h02, 8'h10, 8'h20, 8'h30, 8'h40);
    tick = 1'b1;
    do_load(a);
    tick = 1'b0;
    do_snap(got);
    check("R3 load wins over tick", got, a);
    roll("R2 running counts one per tick", a, 4,
         pk(8'h24, 8'h03, 8'h15, 8'h02, 8'h10, 8'h20, 8'h30, 8'h44));
  endtask

  task automatic t_chain;
    roll("R5 full carry to hours", pk(8'h24, 8'h03, 8'h15, 8'h02, 8'h08, 8'h59, 8'h59, 8'h99), 1,
         pk(8'h24, 8'h03, 8'h15, 8'h02, 8'h09, 8'h00, 8'h00, 8'h00));
    roll("R5 hundredths wrap mid-run", pk(8'h24, 8'h03, 8'h15, 8'h02, 8'h08, 8'h00, 8'h00, 8'h95), 7,
         pk(8'h24, 8'h03, 8'h15, 8'h02, 8'h08, 8'h00, 8'h01, 8'h02));
    roll("R5 minute digit carry", pk(8'h24, 8'h03, 8'h15, 8'h02, 8'h08, 8'h09, 8'h59, 8'h99), 1,
         pk(8'h24, 8'h03, 8'h15, 8'h02, 8'h08, 8'h10, 8'h00, 8'h00));
  endtask

  task automatic t_hours24;
    roll("R6 R8 23 to 00, weekday 7 to 1", pk(8'h24, 8'h05, 8'h15, 8'h17, 8'h23, 8'h59, 8'h59, 8'h99), 1,
         pk(8'h24, 8'h05, 8'h16, 8'h11, 8'h00, 8'h00, 8'h00, 8'h00));
    roll("R6 19 to 20", pk(8'h24, 8'h05, 8'h15, 8'h03, 8'h19, 8'h59, 8'h59, 8'h99), 1,
         pk(8'h24, 8'h05, 8'h15, 8'h03, 8'h20, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic t_hours12;
    roll("R7 11 AM to 12 PM", pk(8'h24, 8'h05, 8'h15, 8'h03, 8'h91, 8'h59, 8'h59, 8'h99), 1,
         pk(8'h24, 8'h05, 8'h15, 8'h03, 8'hB2, 8'h00, 8'h00, 8'h00));
    roll("R7 12 PM to 01 PM", pk(8'h24, 8'h05, 8'h15, 8'h03, 8'hB2, 8'h59, 8'h59, 8'h99), 1,
         pk(8'h24, 8'h05, 8'h15, 8'h03, 8'hA1, 8'h00, 8'h00, 8'h00));
    roll("R7 11 PM to 12 AM next day", pk(8'h24, 8'h05, 8'h15, 8'h03, 8'hB1, 8'h59, 8'h59, 8'h99), 1,
         pk(8'h24, 8'h05, 8'h16, 8'h04, 8'h92, 8'h00, 8'h00, 8'h00));
    roll("R7 09 AM to 10 AM", pk(8'h24, 8'h05, 8'h15, 8'h03, 8'h89, 8'h59, 8'h59, 8'h99), 1,
         pk(8'h24, 8'h05, 8'h15, 8'h03, 8'h90, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic day_end(input string req, input logic [7:0] y, m, d, ey, em, ed);
    roll(req, pk(y, m, d, 8'h01, 8'h23, 8'h59, 8'h59, 8'h99), 1,
         pk(ey, em, ed, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic t_months;
    day_end("R9 April has 30",        8'h24, 8'h04, 8'h30, 8'h24, 8'h05, 8'h01);
    day_end("R9 January has 31",      8'h24, 8'h01, 8'h30, 8'h24, 8'h01, 8'h31);
    day_end("R9 January ends at 31",  8'h24, 8'h01, 8'h31, 8'h24, 8'h02, 8'h01);
    day_end("R9 Feb 28 common year",  8'h23, 8'h02, 8'h28, 8'h23, 8'h03, 8'h01);
    day_end("R9 Feb 28 leap year",    8'h24, 8'h02, 8'h28, 8'h24, 8'h02, 8'h29);
    day_end("R9 Feb 29 leap year",    8'h24, 8'h02, 8'h29, 8'h24, 8'h03, 8'h01);
    day_end("R9 year 00 is leap",     8'h00, 8'h02, 8'h28, 8'h00, 8'h02, 8'h29);
    day_end("R9 year 10 is common",   8'h10, 8'h02, 8'h28, 8'h10, 8'h03, 8'h01);
    day_end("R9 November has 30",     8'h24, 8'h11, 8'h30, 8'h24, 8'h12, 8'h01);
  endtask

  task automatic t_year;
    day_end("R10 December to January", 8'h24, 8'h12, 8'h31, 8'h25, 8'h01, 8'h01);
    day_end("R10 year 99 to 00",       8'h99, 8'h12, 8'h31, 8'h00, 8'h01, 8'h01);
  endtask

  task automatic t_abort;
    logic [63:0] got;
    logic [63:0] a;
    a = pk(8'h24, 8'h01, 8'h01, 8'h22, 8'h12, 8'h34, 8'h56, 8'h78);
    do_load(a);
    ext_rst_n = 1'b0;
    @(negedge clk);
    check("R11 abort when unmasked", {63'b0, xfer_abort}, 64'd1);
    ext_rst_n = 1'b1;
    @(negedge clk);
    check("R11 abort drops with line", {63'b0, xfer_abort}, 64'd0);
    do_snap(got);
    check("R11 abort keeps time", got, a);
    do_load(pk(8'h24, 8'h01, 8'h01, 8'h32, 8'h12, 8'h34, 8'h56, 8'h78));
    ext_rst_n = 1'b0;
    @(negedge clk);
    check("R11 masked line ignored", {63'b0, xfer_abort}, 64'd0);
    @(negedge clk);
    check("R11 masked line still ignored", {63'b0, xfer_abort}, 64'd0);
    ext_rst_n = 1'b1;
  endtask

  task automatic t_snap_hold;
    logic [63:0] got;
    logic [63:0] a;
    a = pk(8'h24, 8'h01, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00);
    do_load(a);
    do_snap(got);
    check("R12 snapshot taken", got, a);
    do_ticks(3);
    @(negedge clk);
    check("R12 snapshot holds while counting", snap_data, a);
    do_snap(got);
    check("R12 new snapshot sees ticks", got,
          pk(8'h24, 8'h01, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00, 8'h03));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stopped();
    t_load_mask();
    t_chain();
    t_hours24();
    t_hours12();
    t_months();
    t_year();
    t_abort();
    t_snap_hold();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule